// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It walks the analog front end through three phases in a fixed loop. The first is a zeroing phase. The second integrates the unknown input for a fixed time. The third ramps the integrator back with the reference. The block drives one active-high select line per phase. During the reference phase it counts clocks, and the count seen at the first comparator zero crossing becomes the conversion result. The result is loaded into an output register at the close of every reference phase. A single-cycle valid pulse and a falling `status_o` mark the new result.

A run/hold level input picks the operating style. Held high, the converter runs freely, and every conversion takes exactly 2^(CNT_W+1) clocks whatever the measured value. Pulled low, it finishes the current reference ramp as soon as the crossing has been seen. It then keeps a guaranteed minimum zeroing time and parks in the zeroing phase until the input rises again. This gives convert-on-demand operation. Both the run/hold input and the comparator input pass through two-flop synchronisers. The run/hold synchroniser presets to high, so the block comes out of reset free-running.

Top module: `adcseq_top`

## Requirements
- R1: Exactly one of `az_o`, `int_o`, `deint_o` is high in every cycle. Integrate is entered only from zeroing, reference only from integrate, and the block returns to zeroing after reference.
- R2: With `run_hold_i` high, zeroing and integrate each last 2^(CNT_W-1) clocks. Reference lasts 2^CNT_W clocks even when a crossing arrives early, so the full loop is 2^(CNT_W+1) clocks.
- R3: `data_o` is loaded only at the end of a reference phase. `data_valid_o` is high for exactly the first zeroing cycle after it, and `data_o` holds its value in every other cycle.
- R4: The loaded value is the `count_o` value of the cycle in which the synchronised crossing is first seen. If the crossing pin rises in the cycle showing count K, the result is K+2. With no crossing, the result is all ones.
- R5: Only the first crossing in a reference phase sets the result. Later pulses in the same phase leave it unchanged.
- R6: If `run_hold_i` is low (after synchronising) in a reference cycle that follows the one where the crossing was registered, the reference phase ends at that cycle's edge. With the crossing pin raised at count K and `run_hold_i` already low, reference lasts K+4 cycles. A low `run_hold_i` before any crossing does not shorten reference.
- R7: With the synchronised `run_hold_i` low, zeroing lasts at least MIN_AZ cycles and then waits in zeroing for as long as it stays low. If it turns high again before the zeroing count reaches MIN_AZ-1, zeroing runs its full free-running length.
- R8: After a wait, integrate starts RESTART_DLY (7) clocks after the edge at which the synchronised `run_hold_i` is first seen high. From the pin rising, this is the tenth rising edge. `status_o` rises in that same cycle.
- R9: `status_o` is high throughout integrate and reference. It falls in the same cycle that `data_valid_o` pulses.
- R10: A synchronous active-high `rst_i` gives `az_o`=1, `int_o`=`deint_o`=0, `status_o`=0, `data_valid_o`=0, `data_o`=0 and `count_o`=0.
- R11: During reference, `count_o` starts at 0 and increases by one per clock. Outside reference it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_hold_i | input | 1 | High: free-run; low: stop after the current result |
| zero_cross_i | input | 1 | Comparator output, high once the integrator crosses zero |
| az_o | output | 1 | Zeroing phase select |
| int_o | output | 1 | Signal integrate phase select |
| deint_o | output | 1 | Reference de-integrate phase select |
| count_o | output | CNT_W | Running reference-phase count |
| data_o | output | CNT_W | Last conversion result |
| data_valid_o | output | 1 | One-cycle pulse when `data_o` is updated |
| status_o | output | 1 | High while a conversion is in progress |

## Verification
On every cycle the assertions check the local shape of the sequence. They cover the one-hot phase selects and the legal phase order, the step-by-one reference count, where valid pulses and status edges may occur, the hold on the result register, and the minimum length of each zeroing phase. The actual numbers are shown only by the bench scenarios: the exact phase lengths, the K+2 result latency through the synchroniser, the K+4 length of a cut-short reference phase, the ten-edge restart delay, and the boundary between a full zeroing phase and a wait. A seeded random mix of crossing positions, free-run and on-demand conversions, and restart times sits on top of directed runs covering no crossing, a double crossing and a long hold.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    // Sequencer states; WAIT and ARM are sub-states of the zeroing phase
    typedef enum logic [2:0] {
        ST_AZ   = 3'd0,
        ST_WAIT = 3'd1,
        ST_ARM  = 3'd2,
        ST_INT  = 3'd3,
        ST_DE   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [1:0] ff_q;
    logic [1:0] ff_d;

    always_comb begin
        ff_d = {ff_q[0], d_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ff_q <= {2{RST_VAL}};
        end else begin
            ff_q <= ff_d;
        end
    end

    assign q_o = ff_q[1];

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MIN_AZ      = 64,
    parameter int RESTART_DLY = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_s_i,
    input  logic             zc_s_i,
    output logic             az_o,
    output logic             int_o,
    output logic             deint_o,
    output logic [CNT_W-1:0] count_o,
    output logic             status_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o
);

    // Zeroing and integrate share one length; reference is twice as long
    localparam logic [CNT_W-1:0] HALF_LAST = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] DE_LAST   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MIN_LAST  = CNT_W'(MIN_AZ - 1);
    localparam logic [CNT_W-1:0] ARM_LAST  = CNT_W'(RESTART_DLY - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] ph;
        logic             seen;
        logic [CNT_W-1:0] frz;
        logic             stat;
    } ctrl_t;

    ctrl_t r_q;
    ctrl_t r_d;
    logic  load_d;

    always_comb begin
        r_d    = r_q;
        load_d = 1'b0;
        case (r_q.st)
            ST_AZ: begin
                if (!run_s_i && (r_q.ph >= MIN_LAST)) begin
                    r_d.st = ST_WAIT;
                end else if (r_q.ph == HALF_LAST) begin
                    r_d.st   = ST_INT;
                    r_d.ph   = '0;
                    r_d.stat = 1'b1;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            ST_WAIT: begin
                if (run_s_i) begin
                    r_d.st = ST_ARM;
                    r_d.ph = '0;
                end
            end
            ST_ARM: begin
                if (r_q.ph == ARM_LAST) begin
                    r_d.st   = ST_INT;
                    r_d.ph   = '0;
                    r_d.stat = 1'b1;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            ST_INT: begin
                if (r_q.ph == HALF_LAST) begin
                    r_d.st   = ST_DE;
                    r_d.ph   = '0;
                    r_d.seen = 1'b0;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            ST_DE: begin
                // first synchronised crossing freezes the count
                if (zc_s_i && !r_q.seen) begin
                    r_d.seen = 1'b1;
                    r_d.frz  = r_q.ph;
                end
                if ((r_q.ph == DE_LAST) || (r_q.seen && !run_s_i)) begin
                    load_d   = 1'b1;
                    r_d.st   = ST_AZ;
                    r_d.ph   = '0;
                    r_d.stat = 1'b0;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            default: begin
                r_d.st   = ST_AZ;
                r_d.ph   = '0;
                r_d.stat = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.st   <= ST_AZ;
            r_q.ph   <= '0;
            r_q.seen <= 1'b0;
            r_q.frz  <= '0;
            r_q.stat <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign az_o       = (r_q.st == ST_AZ) || (r_q.st == ST_WAIT) || (r_q.st == ST_ARM);
    assign int_o      = (r_q.st == ST_INT);
    assign deint_o    = (r_q.st == ST_DE);
    assign count_o    = deint_o ? r_q.ph : '0;
    assign status_o   = r_q.stat;
    assign load_o     = load_d;
    assign load_val_o = r_q.seen ? r_q.frz : r_q.ph;

endmodule

// File: rtl/adcseq_latch.sv
module adcseq_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic [CNT_W-1:0] data_o,
    output logic             valid_o
);

    typedef struct packed {
        logic [CNT_W-1:0] data;
        logic             valid;
    } lat_t;

    lat_t l_q;
    lat_t l_d;

    always_comb begin
        l_d.data  = load_i ? val_i : l_q.data;
        l_d.valid = load_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            l_q.data  <= '0;
            l_q.valid <= 1'b0;
        end else begin
            l_q <= l_d;
        end
    end

    assign data_o  = l_q.data;
    assign valid_o = l_q.valid;

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
    parameter int CNT_W       = 16,
    parameter int MIN_AZ      = 64,
    parameter int RESTART_DLY = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_hold_i,
    input  logic             zero_cross_i,
    output logic             az_o,
    output logic             int_o,
    output logic             deint_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] data_o,
    output logic             data_valid_o,
    output logic             status_o
);

    // index 0: comparator (rests low), index 1: run/hold (rests high)
    logic [1:0]       raw_in;
    logic [1:0]       syn_in;
    logic             load;
    logic [CNT_W-1:0] load_val;

    assign raw_in = {run_hold_i, zero_cross_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_sync
        adcseq_sync #(
            .RST_VAL(gi == 1)
        ) u_sync (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .d_i   (raw_in[gi]),
            .q_o   (syn_in[gi])
        );
    end

    adcseq_ctrl #(
        .CNT_W      (CNT_W),
        .MIN_AZ     (MIN_AZ),
        .RESTART_DLY(RESTART_DLY)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_s_i   (syn_in[1]),
        .zc_s_i    (syn_in[0]),
        .az_o      (az_o),
        .int_o     (int_o),
        .deint_o   (deint_o),
        .count_o   (count_o),
        .status_o  (status_o),
        .load_o    (load),
        .load_val_o(load_val)
    );

    adcseq_latch #(
        .CNT_W(CNT_W)
    ) u_latch (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .val_i  (load_val),
        .data_o (data_o),
        .valid_o(data_valid_o)
    );

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int CNT_W  = 16,
    parameter int MIN_AZ = 64
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             az_o,
    input logic             int_o,
    input logic             deint_o,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] data_o,
    input logic             data_valid_o,
    input logic             status_o
);

    // length of the current zeroing run, saturating
    int unsigned az_run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            az_run_q <= 0;
        end else if (az_o) begin
            if (az_run_q != 32'hFFFF_FFFF) az_run_q <= az_run_q + 1;
        end else begin
            az_run_q <= 0;
        end
    end

    AST_PHASE_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({az_o, int_o, deint_o}) == 1);  // R1
    AST_INT_AFTER_AZ: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(int_o) |-> $past(az_o));  // R1
    AST_DE_AFTER_INT: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(deint_o) |-> $past(int_o));  // R1
    AST_VALID_AT_END: assert property (@(posedge clk_i) disable iff (rst_i)
        data_valid_o |-> (az_o && $past(deint_o)));  // R3
    AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !data_valid_o |=> (data_valid_o || $stable(data_o)));  // R3
    AST_MIN_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(int_o) |-> (az_run_q >= MIN_AZ));  // R7
    AST_STATUS_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(status_o) |-> $rose(int_o));  // R8
    AST_STATUS_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(status_o) |-> data_valid_o);  // R9
    AST_STATUS_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        (int_o || deint_o) |-> status_o);  // R9
    AST_COUNT_START: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(deint_o) |-> (count_o == '0));  // R11
    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (deint_o && $past(deint_o)) |-> (count_o == $past(count_o) + 1'b1));  // R11
    AST_COUNT_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !deint_o |-> (count_o == '0));  // R11

endmodule

bind adcseq_top adcseq_chk #(
    .CNT_W (CNT_W),
    .MIN_AZ(MIN_AZ)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .az_o        (az_o),
    .int_o       (int_o),
    .deint_o     (deint_o),
    .count_o     (count_o),
    .data_o      (data_o),
    .data_valid_o(data_valid_o),
    .status_o    (status_o)
);

// File: tb/sim_adcseq_top.sv
`timescale 1ns/1ps
module sim_adcseq_top;

    localparam int W      = 6;
    localparam int MINZ   = 5;
    localparam int HALF   = 1 << (W - 1);
    localparam int DE_LEN = 1 << W;
    localparam int ALL1   = DE_LEN - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         run;
    logic         zc;
    logic         az_o, int_o, deint_o, data_valid_o, status_o;
    logic [W-1:0] count_o, data_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    adcseq_top #(.CNT_W(W), .MIN_AZ(MINZ), .RESTART_DLY(7)) u0 (
        .clk_i(clk), .rst_i(rst), .run_hold_i(run), .zero_cross_i(zc),
        .az_o(az_o), .int_o(int_o), .deint_o(deint_o), .count_o(count_o),
        .data_o(data_o), .data_valid_o(data_valid_o), .status_o(status_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected zeroing length when run/hold rises c cycles after the valid pulse
    function automatic int exp_az(input int c);
        return (c >= MINZ - 2) ? c + 10 : HALF;
    endfunction

    function automatic int exp_de(input bit cut, input int k);
        return cut ? k + 4 : DE_LEN;
    endfunction

    task automatic wait_de_start();
        do @(negedge clk); while (!(deint_o && count_o == '0));
    endtask

    task automatic wait_count(input int k);
        while (int'(count_o) != k) @(negedge clk);
    endtask

    task automatic wait_dv(output int last);
        last = -1;
        do begin
            @(negedge clk);
            if (deint_o) last = int'(count_o);
        end while (!data_valid_o);
    endtask

    task automatic az_len_from(input int c, output int n);
        n = c;
        while (az_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4242);
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int last, n, ni, nd, k, c, prev;
        bit cnt_ok, mode;
        rst = 1'b1;
        run = 1'b1;
        zc  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "az_o", az_o, 1);
        chk("R10", "int_o|deint_o", int_o | deint_o, 0);
        chk("R10", "status_o", status_o, 0);
        chk("R10", "data_valid_o", data_valid_o, 0);
        chk("R10", "data_o", data_o, 0);
        chk("R10", "count_o", count_o, 0);
        rst = 1'b0;

        // free-running, no crossing
        wait_dv(last);
        chk("R4", "no-crossing result", data_o, ALL1);
        chk("R2", "first reference length", last + 1, DE_LEN);
        chk("R9", "status at valid", status_o, 0);
        chk("R3", "valid in zeroing", az_o, 1);
        prev = data_o;
        az_len_from(0, n);
        chk("R2", "zeroing length", n, HALF);
        chk("R9", "status at integrate start", status_o, 1);
        chk("R3", "data held into integrate", data_o, prev);
        ni = 0;
        while (int_o) begin ni++; @(negedge clk); end
        chk("R2", "integrate length", ni, HALF);
        nd = 0;
        cnt_ok = 1'b1;
        while (deint_o) begin
            if (int'(count_o) != nd) cnt_ok = 1'b0;
            nd++;
            @(negedge clk);
        end
        chk("R11", "count steps", cnt_ok, 1);
        chk("R2", "reference length", nd, DE_LEN);
        chk("R3", "valid right after reference", data_valid_o, 1);
        chk("R2", "full loop", n + ni + nd, 2 * DE_LEN);
        chk("R11", "count idle in zeroing", count_o, 0);

        // crossing at count 0
        wait_de_start();
        zc = 1'b1;
        wait_dv(last);
        zc = 1'b0;
        chk("R4", "crossing at 0", data_o, 2);
        chk("R2", "early crossing keeps length", last + 1, DE_LEN);

        // crossing near the end
        wait_de_start();
        wait_count(DE_LEN - 4);
        zc = 1'b1;
        wait_dv(last);
        zc = 1'b0;
        chk("R4", "late crossing", data_o, DE_LEN - 2);

        // two pulses: only the first counts
        wait_de_start();
        wait_count(10);
        zc = 1'b1;
        repeat (3) @(negedge clk);
        zc = 1'b0;
        repeat (2) @(negedge clk);
        zc = 1'b1;
        wait_dv(last);
        zc = 1'b0;
        chk("R5", "second pulse ignored", data_o, 12);

        // run low without crossing: full reference, then long hold
        wait_de_start();
        run = 1'b0;
        wait_dv(last);
        chk("R6", "low run without crossing", last + 1, DE_LEN);
        chk("R4", "no crossing result", data_o, ALL1);
        mode = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (!az_o) mode = 1'b1;
        end
        chk("R7", "held in zeroing", mode, 0);
        run = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!int_o && n < 50);
        chk("R8", "restart edges", n, 10);
        chk("R8", "status with integrate", status_o, 1);

        // early termination and the minimum zeroing boundary
        for (int ci = 2; ci <= 3; ci++) begin
            wait_de_start();
            run = 1'b0;
            wait_count(20);
            zc = 1'b1;
            wait_dv(last);
            zc = 1'b0;
            chk("R6", "cut reference length", last + 1, 24);
            chk("R4", "cut result", data_o, 22);
            repeat (ci) @(negedge clk);
            run = 1'b1;
            az_len_from(ci, n);
            chk("R7", "zeroing vs minimum", n, exp_az(ci));
        end

        // seeded random mix
        for (int it = 0; it < 24; it++) begin
            wait_de_start();
            k    = $urandom_range(2, DE_LEN - 6);
            mode = 1'($urandom_range(0, 1));
            if (mode) run = 1'b0;
            wait_count(k);
            zc = 1'b1;
            wait_dv(last);
            zc = 1'b0;
            chk("R4", "random result", data_o, k + 2);
            chk("R6", "random reference length", last + 1, exp_de(mode, k));
            c = mode ? $urandom_range(0, 6) : 0;
            repeat (c) @(negedge clk);
            run = 1'b1;
            az_len_from(c, n);
            chk("R7", "random zeroing length", n, mode ? exp_az(c) : HALF);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule